// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block moves 8-bit channels between eight serial TDM input lanes and eight serial TDM output lanes. Every lane carries a 256-bit frame, which is 32 byte-wide channels. Each received byte is stored in a two-bank data store. A connection store holds one 16-bit entry for each output channel. The entry names the input lane and channel that the output channel replays. It also decides whether the channel is driven, and it can put a fixed host-supplied byte in place of switched data. One flag bit from each entry is sent out as a separate serial control lane, one entry per bit time.

An external timing block supplies the bit timing. `bit_en` marks one serial bit time, and `bit_pos` gives that bit's index within the frame. The block does nothing between strobes. Software programs the connection store over a small asynchronous host bus. The bus has an active-low select, an active-high strobe, a read/write line, split write and read data, and an active-low acknowledge.

Top module: `tdm_slot_switch`

## Requirements
- R1: While reset is asserted, and after it is released until the first bit strobe, `ser_oe` is all zeros, `ctl_out` is 0, `host_ack_n` is 1 and `host_rdata_oe` is 0.
- R2: An access starts when `host_cs_n`=0 and `host_ds`=1. The block then drives `host_ack_n` low from the next clock until the strobe ends, and returns it high one clock later. A write with `host_rw`=0 stores `host_wdata`. A read with `host_rw`=1 returns the stored byte on `host_rdata` while `host_rdata_oe` is 1. `host_addr[8]` picks the flag byte (1) or the route byte (0). `host_addr[7:0]` is the entry index.
- R3: For a bit strobe taken with `out_en`=0, all eight `ser_oe` bits are 0 from the next clock.
- R4: When flag-byte bit 0 (drive) of entry o*32+k is 0, output lane o is not driven during channel k.
- R5: Serial bits are MSB first. `bit_pos[7:3]` is the channel and `bit_pos[2:0]` is the bit within the byte. Route-byte bits [7:5] give the source lane and bits [4:0] give the source channel. A driven output channel replays that source byte.
- R6: When flag-byte bit 2 (message) is 1, the route byte itself is sent as the channel data.
- R7: During bit time p, `ctl_out` carries flag-byte bit 1 of entry p. Entry p belongs to lane p/32, channel p%32.
- R8: Bytes received in frame N are sent in frame N+1, never in frame N. Banks swap after the strobe with `bit_pos`=255.
- R9: The outputs for bit position p change one clock after the strobe that carries p. They hold until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One serial bit time |
| bit_pos | input | 8 | Bit index within the frame |
| ser_in | input | 8 | Serial input lanes |
| out_en | input | 1 | Global output enable |
| ser_out | output | 8 | Serial output data |
| ser_oe | output | 8 | Per-lane drive enable (0 = high impedance) |
| ctl_out | output | 1 | Serial control lane |
| host_cs_n | input | 1 | Host select, active low |
| host_ds | input | 1 | Host data strobe, active high |
| host_rw | input | 1 | 1 = read, 0 = write |
| host_addr | input | 9 | Half select and entry index |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| host_rdata_oe | output | 1 | Read data drive enable |
| host_ack_n | output | 1 | Access acknowledge, active low |

## Verification
The hardest case to reach is the bank swap. A wrong bank shows up only if the switched byte for a slot changes from one frame to the next. The bench therefore gives every input byte a value that depends on the frame number. It runs back-to-back frames and predicts each output bit from the previous frame's bytes. A routing map that mixes lanes, channels, undriven slots and message slots covers every entry in one pass. A frame with idle cycles between strobes exercises the hold behaviour.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int STRM_W = 3;
  localparam int CHAN_W = 5;
  localparam int BYTE_W = 8;
  localparam int FLG_DRV = 0;
  localparam int FLG_CTL = 1;
  localparam int FLG_MSG = 2;
  localparam int FLG_N   = 3;
endpackage

// File: rtl/tsi_rx_store.sv
module tsi_rx_store #(
  parameter  int STRM_W = tsi_pkg::STRM_W,
  parameter  int CHAN_W = tsi_pkg::CHAN_W,
  parameter  int BYTE_W = tsi_pkg::BYTE_W,
  localparam int NS     = 1 << STRM_W,
  localparam int BIT_W  = $clog2(BYTE_W),
  localparam int POS_W  = CHAN_W + BIT_W,
  localparam int ADDR_W = STRM_W + CHAN_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bit_en,
  input  logic [POS_W-1:0]               pos,
  input  logic [NS-1:0]                  ser_in,
  input  logic [NS-1:0][ADDR_W-1:0]      rd_addr,
  output logic [NS-1:0][BYTE_W-1:0]      rd_data
);
  localparam int SLOTS = NS << CHAN_W;

  logic [BYTE_W-2:0] sh_q [NS];
  logic [BYTE_W-2:0] sh_d [NS];
  logic              bank_q, bank_d;
  logic              byte_done, frame_end;
  logic [BYTE_W-1:0] mem [2][SLOTS];

  assign byte_done = bit_en && (pos[BIT_W-1:0] == BIT_W'(BYTE_W-1));
  assign frame_end = bit_en && (&pos);

  always_comb begin
    bank_d = bank_q ^ frame_end;
    for (int s = 0; s < NS; s++) begin
      sh_d[s] = bit_en ? {sh_q[s][BYTE_W-3:0], ser_in[s]} : sh_q[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= 1'b0;
      for (int s = 0; s < NS; s++) sh_q[s] <= '0;
    end else begin
      bank_q <= bank_d;
      for (int s = 0; s < NS; s++) sh_q[s] <= sh_d[s];
    end
  end

  always_ff @(posedge clk) begin
    if (byte_done) begin
      for (int s = 0; s < NS; s++) begin
        mem[bank_q][{STRM_W'(s), pos[POS_W-1:BIT_W]}] <= {sh_q[s], ser_in[s]};
      end
    end
  end

  for (genvar o = 0; o < NS; o++) begin : g_rd
    assign rd_data[o] = mem[~bank_q][rd_addr[o]];
  end

  p_bank_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (bank_q != $past(bank_q)));
  p_bank_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(bank_q));
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem #(
  parameter  int STRM_W = tsi_pkg::STRM_W,
  parameter  int CHAN_W = tsi_pkg::CHAN_W,
  parameter  int BYTE_W = tsi_pkg::BYTE_W,
  localparam int NS     = 1 << STRM_W,
  localparam int ADDR_W = STRM_W + CHAN_W,
  localparam int FLG_N  = tsi_pkg::FLG_N
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cs_n,
  input  logic                        ds,
  input  logic                        rw,
  input  logic [ADDR_W:0]             addr,
  input  logic [BYTE_W-1:0]           wdata,
  output logic [BYTE_W-1:0]           rdata,
  output logic                        rdata_oe,
  output logic                        ack_n,
  input  logic [NS-1:0][ADDR_W-1:0]   port_addr,
  output logic [NS-1:0][BYTE_W-1:0]   port_route,
  output logic [NS-1:0][FLG_N-1:0]    port_flags,
  input  logic [ADDR_W-1:0]           ctl_addr,
  output logic                        ctl_bit
);
  localparam int SLOTS = 1 << ADDR_W;

  logic [BYTE_W-1:0] route_m [SLOTS];
  logic [BYTE_W-1:0] flag_m  [SLOTS];

  logic              strobe, start;
  logic              strobe_q, ack_q, rdoe_q;
  logic              ack_d, rdoe_d;
  logic [BYTE_W-1:0] rdata_q, rdata_d;
  logic [ADDR_W-1:0] idx;

  assign strobe = !cs_n && ds;
  assign start  = strobe && !strobe_q;
  assign idx    = addr[ADDR_W-1:0];

  always_comb begin
    ack_d   = !strobe;
    rdoe_d  = strobe && rw;
    rdata_d = rdata_q;
    if (start && rw) rdata_d = addr[ADDR_W] ? flag_m[idx] : route_m[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      ack_q    <= 1'b1;
      rdoe_q   <= 1'b0;
      rdata_q  <= '0;
    end else begin
      strobe_q <= strobe;
      ack_q    <= ack_d;
      rdoe_q   <= rdoe_d;
      rdata_q  <= rdata_d;
    end
  end

  always_ff @(posedge clk) begin
    if (start && !rw) begin
      if (addr[ADDR_W]) flag_m[idx] <= wdata;
      else              route_m[idx] <= wdata;
    end
  end

  assign ack_n    = ack_q;
  assign rdata_oe = rdoe_q;
  assign rdata    = rdata_q;

  for (genvar o = 0; o < NS; o++) begin : g_port
    assign port_route[o] = route_m[port_addr[o]];
    assign port_flags[o] = flag_m[port_addr[o]][FLG_N-1:0];
  end
  assign ctl_bit = flag_m[ctl_addr][tsi_pkg::FLG_CTL];

  p_ack_on_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !ack_n);
  p_ack_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> ack_n);
  p_rdoe_in_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> !ack_n);
endmodule

// File: rtl/tsi_tx_shift.sv
module tsi_tx_shift #(
  parameter  int STRM_W = tsi_pkg::STRM_W,
  parameter  int CHAN_W = tsi_pkg::CHAN_W,
  parameter  int BYTE_W = tsi_pkg::BYTE_W,
  localparam int NS     = 1 << STRM_W,
  localparam int BIT_W  = $clog2(BYTE_W),
  localparam int POS_W  = CHAN_W + BIT_W,
  localparam int FLG_N  = tsi_pkg::FLG_N
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bit_en,
  input  logic [POS_W-1:0]           pos,
  input  logic                       out_en,
  input  logic [NS-1:0][BYTE_W-1:0]  route,
  input  logic [NS-1:0][FLG_N-1:0]   flags,
  input  logic [NS-1:0][BYTE_W-1:0]  sw_data,
  input  logic                       ctl_bit,
  output logic [NS-1:0]              ser_out,
  output logic [NS-1:0]              ser_oe,
  output logic                       ctl_out
);
  logic [NS-1:0] out_q, out_d, oe_q, oe_d, bit_v, drv_v;
  logic          ctl_q, ctl_d;
  logic [BIT_W-1:0] sel;

  assign sel = BIT_W'(BYTE_W-1) - pos[BIT_W-1:0];

  for (genvar o = 0; o < NS; o++) begin : g_lane
    logic [BYTE_W-1:0] chan_byte;
    assign chan_byte = flags[o][tsi_pkg::FLG_MSG] ? route[o] : sw_data[o];
    assign bit_v[o]  = chan_byte[sel];
    assign drv_v[o]  = out_en && flags[o][tsi_pkg::FLG_DRV];
  end

  always_comb begin
    out_d = bit_en ? bit_v   : out_q;
    oe_d  = bit_en ? drv_v   : oe_q;
    ctl_d = bit_en ? ctl_bit : ctl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      oe_q  <= '0;
      ctl_q <= 1'b0;
    end else begin
      out_q <= out_d;
      oe_q  <= oe_d;
      ctl_q <= ctl_d;
    end
  end

  assign ser_out = out_q;
  assign ser_oe  = oe_q;
  assign ctl_out = ctl_q;

  p_global_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !out_en) |=> (ser_oe == '0));
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(ser_out) && $stable(ser_oe) && $stable(ctl_out)));
endmodule

// File: rtl/tdm_slot_switch.sv
module tdm_slot_switch #(
  parameter  int STRM_W = tsi_pkg::STRM_W,
  parameter  int CHAN_W = tsi_pkg::CHAN_W,
  parameter  int BYTE_W = tsi_pkg::BYTE_W,
  localparam int NS     = 1 << STRM_W,
  localparam int BIT_W  = $clog2(BYTE_W),
  localparam int POS_W  = CHAN_W + BIT_W,
  localparam int ADDR_W = STRM_W + CHAN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [POS_W-1:0]  bit_pos,
  input  logic [NS-1:0]     ser_in,
  input  logic              out_en,
  output logic [NS-1:0]     ser_out,
  output logic [NS-1:0]     ser_oe,
  output logic              ctl_out,
  input  logic              host_cs_n,
  input  logic              host_ds,
  input  logic              host_rw,
  input  logic [ADDR_W:0]   host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  output logic              host_rdata_oe,
  output logic              host_ack_n
);
  localparam int FLG_N = tsi_pkg::FLG_N;

  logic rs1_q, rs2_q, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign srst_n = rs2_q;

  logic [NS-1:0][ADDR_W-1:0] cm_addr, src_addr;
  logic [NS-1:0][BYTE_W-1:0] route, sw_data;
  logic [NS-1:0][FLG_N-1:0]  flags;
  logic                      ctl_bit;

  for (genvar o = 0; o < NS; o++) begin : g_addr
    assign cm_addr[o]  = {STRM_W'(o), bit_pos[POS_W-1:BIT_W]};
    assign src_addr[o] = route[o][ADDR_W-1:0];
  end

  tsi_rx_store #(.STRM_W(STRM_W), .CHAN_W(CHAN_W), .BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(srst_n), .bit_en(bit_en), .pos(bit_pos),
    .ser_in(ser_in), .rd_addr(src_addr), .rd_data(sw_data)
  );

  tsi_conn_mem #(.STRM_W(STRM_W), .CHAN_W(CHAN_W), .BYTE_W(BYTE_W)) u_cm (
    .clk(clk), .rst_n(srst_n), .cs_n(host_cs_n), .ds(host_ds), .rw(host_rw),
    .addr(host_addr), .wdata(host_wdata), .rdata(host_rdata),
    .rdata_oe(host_rdata_oe), .ack_n(host_ack_n),
    .port_addr(cm_addr), .port_route(route), .port_flags(flags),
    .ctl_addr(ADDR_W'(bit_pos)), .ctl_bit(ctl_bit)
  );

  tsi_tx_shift #(.STRM_W(STRM_W), .CHAN_W(CHAN_W), .BYTE_W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(srst_n), .bit_en(bit_en), .pos(bit_pos),
    .out_en(out_en), .route(route), .flags(flags), .sw_data(sw_data),
    .ctl_bit(ctl_bit), .ser_out(ser_out), .ser_oe(ser_oe), .ctl_out(ctl_out)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    !srst_n |=> (ser_oe == '0 && host_ack_n && !host_rdata_oe));
endmodule

// File: tb/tb_tdm_slot_switch.sv
module tb_tdm_slot_switch;
  logic       clk = 1'b0;
  logic       rst_n, bit_en, out_en, ctl_out;
  logic [7:0] bit_pos, ser_in, ser_out, ser_oe;
  logic       host_cs_n, host_ds, host_rw, host_rdata_oe, host_ack_n;
  logic [8:0] host_addr;
  logic [7:0] host_wdata, host_rdata;

  int total = 0;
  int fails = 0;
  logic [7:0] sh_route [256];
  logic [7:0] sh_flag  [256];

  always #5 clk = ~clk;

  tdm_slot_switch dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_pos(bit_pos),
    .ser_in(ser_in), .out_en(out_en), .ser_out(ser_out), .ser_oe(ser_oe),
    .ctl_out(ctl_out), .host_cs_n(host_cs_n), .host_ds(host_ds),
    .host_rw(host_rw), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rdata_oe(host_rdata_oe),
    .host_ack_n(host_ack_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] in_byte(input int s, input int f, input int c);
    return 8'(s * 29 + c * 11 + f * 67 + 5);
  endfunction

  task automatic host_xfer(input bit rd, input logic [8:0] a, input logic [7:0] wd,
                           output logic [7:0] rv);
    int n;
    @(negedge clk);
    host_cs_n = 1'b0; host_ds = 1'b1; host_rw = rd; host_addr = a; host_wdata = wd;
    n = 0;
    do begin @(negedge clk); n++; end while (host_ack_n && n < 8);
    chk(!host_ack_n, "R2 ack low", host_ack_n, 0);
    rv = host_rdata;
    if (rd) chk(host_rdata_oe, "R2 rdata_oe", host_rdata_oe, 1);
    host_ds = 1'b0; host_cs_n = 1'b1;
    @(negedge clk);
    chk(host_ack_n, "R2 ack release", host_ack_n, 1);
  endtask

  task automatic host_wr(input logic [8:0] a, input logic [7:0] d);
    logic [7:0] dummy;
    host_xfer(1'b0, a, d, dummy);
    if (a[8]) sh_flag[a[7:0]] = d; else sh_route[a[7:0]] = d;
  endtask

  task automatic check_bit(input int f, input int p);
    int k, b, loc;
    logic [7:0] rt, fl, by;
    logic drv;
    string req;
    k = p >> 3; b = p & 7;
    for (int o = 0; o < 8; o++) begin
      loc = o * 32 + k;
      rt = sh_route[loc]; fl = sh_flag[loc];
      drv = out_en && fl[0];
      by = fl[2] ? rt : in_byte(int'(rt[7:5]), f - 1, int'(rt[4:0]));
      req = !out_en ? "R3" : !fl[0] ? "R4" : fl[2] ? "R6" : "R5 R8";
      if (drv) chk(ser_oe[o] && ser_out[o] == by[7-b], req,
                   {ser_oe[o], ser_out[o]}, {1'b1, by[7-b]});
      else     chk(!ser_oe[o], req, ser_oe[o], 0);
    end
    chk(ctl_out == sh_flag[p][1], "R7 control lane", ctl_out, sh_flag[p][1]);
  endtask

  task automatic run_frame(input int f, input int gap, input bit check);
    for (int p = 0; p < 256; p++) begin
      bit_en = 1'b1; bit_pos = 8'(p);
      for (int s = 0; s < 8; s++) ser_in[s] = in_byte(s, f, p >> 3)[7 - (p & 7)];
      @(negedge clk);
      bit_en = 1'b0;
      if (check) check_bit(f, p);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        if (check) check_bit(f, p);   // R9 hold between strobes
      end
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; bit_en = 1'b0; bit_pos = '0; ser_in = '0; out_en = 1'b1;
    host_cs_n = 1'b1; host_ds = 1'b0; host_rw = 1'b1; host_addr = '0; host_wdata = '0;
    repeat (4) @(negedge clk);
    chk(ser_oe == 0 && !ctl_out, "R1 outputs in reset", {ser_oe, ctl_out}, 0);
    chk(host_ack_n && !host_rdata_oe, "R1 host in reset", {host_ack_n, host_rdata_oe}, 2);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ser_oe == 0 && host_ack_n, "R1 after release", {ser_oe, host_ack_n}, 1);
  endtask

  task automatic t_host;
    logic [7:0] r;
    host_wr(9'h105, 8'h5A);
    host_wr(9'h005, 8'hA5);
    host_xfer(1'b1, 9'h105, 8'h00, r);
    chk(r == 8'h5A, "R2 flag readback", r, 8'h5A);
    host_xfer(1'b1, 9'h005, 8'h00, r);
    chk(r == 8'hA5, "R2 route readback", r, 8'hA5);
  endtask

  task automatic t_program;
    logic [7:0] rt, fl;
    for (int o = 0; o < 8; o++) begin
      for (int k = 0; k < 32; k++) begin
        rt = {3'((o + 3) % 8), 5'((k * 7 + 1) % 32)};
        fl = 8'h00;
        fl[0] = (k != 5);
        fl[1] = ((k + o) % 3 == 0);
        fl[2] = (o == 6 && k % 4 == 2);
        if (fl[2]) rt = 8'(8'hC3 ^ k);
        host_wr({1'b0, 3'(o), 5'(k)}, rt);
        host_wr({1'b1, 3'(o), 5'(k)}, fl);
      end
    end
  endtask

  task automatic t_switch;
    out_en = 1'b1;
    run_frame(0, 0, 1'b0);
    run_frame(1, 0, 1'b1);   // R5 R8 R4 R6 R7
    run_frame(2, 1, 1'b1);   // R9 with idle cycles
  endtask

  task automatic t_global_off;
    out_en = 1'b0;
    run_frame(3, 0, 1'b1);   // R3
    out_en = 1'b1;
    run_frame(4, 0, 1'b1);
  endtask

  initial begin
    t_reset;
    t_host;
    t_program;
    t_switch;
    t_global_off;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(200000 * 10);
    total++; fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule